// File: doc/BRIEF.md
# Shadow RAM Address Remapper

This block sits between an 8-bit processor bus and a 64K RAM whose upper half can act as a shadow copy of the lower half. On each RAM access it chooses whether the processor's address goes to the lower 32K bank or is moved up by 32K into the shadow bank. It also tells the clock logic whether the access needs a slow, half-rate cycle.

The choice depends on a 2-bit mode input and on two internal flags. The enable flag is a one-bit control register written at I/O address 0xFC7F. The driver flag records whether the most recent opcode fetch came from the display-driver code region (0xC000 to 0xDFFF). In shadow mode, code running from that region reads and writes the real screen RAM. Code running anywhere else sees the shadow bank instead, so a program can use the full lower 32K while the screen stays put.

The remapped address is combinational. It uses the current address and mode together with the registered flags, so it is ready in the same cycle as the access.

Top module: `shadow_remap`

## Requirements
- R1: After reset the enable flag is set and the driver flag is clear. In shadow mode (mode=2) a read of 0x3000 with no preceding fetch is therefore sent to 0xB000.
- R2: A write to 0xFC7F sets the enable flag to the inverse of data bit 7. Bit 7 = 0 enables remapping and bit 7 = 1 disables it. While the flag is clear, no RAM address is remapped in any mode.
- R3: A read with sync high (an opcode fetch) sets the driver flag when (addr & 0xE000) == 0xC000 and clears it otherwise. The new value takes effect from the next clock cycle.
- R4: Reads without sync and all writes leave the driver flag unchanged.
- R5: In turbo mode (mode=1) with the enable flag set, RAM addresses below 0x3000 have 0x8000 added. All other RAM addresses in turbo mode pass through unchanged.
- R6: In shadow mode (mode=2) with the enable flag set, a RAM address has 0x8000 added when it is below 0x3000 or when the driver flag is clear. Otherwise it passes through unchanged.
- R7: In normal mode (mode=0, and mode=3 which behaves the same) no address is remapped, and every RAM access raises slow_cycle.
- R8: In turbo and shadow modes slow_cycle is never raised.
- R9: Addresses of 0x8000 and above, including the 0xFC00 I/O page, pass through unchanged. They give ram_hit=0 and slow_cycle=0. Cycles with neither rd nor wr also give ram_hit=0 and slow_cycle=0.
- R10: ram_addr, ram_hit and slow_cycle are valid in the same cycle as the access. This includes an opcode fetch from RAM, which is remapped using the driver flag as it stood before that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_sync | input | 1 | High during an opcode fetch |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data (bit 7 used by the enable register) |
| mode | input | 2 | 0 normal, 1 turbo, 2 shadow, 3 as normal |
| ram_addr | output | 16 | Address presented to the 64K RAM |
| ram_hit | output | 1 | Current access targets the RAM window |
| slow_cycle | output | 1 | Request a half-rate cycle for this access |

## Verification
A wrong driver flag shows up in shadow mode on the first RAM access at or above 0x3000 after the fetch that should have set or cleared it. That access lands in the wrong 32K bank one cycle after the fetch. A wrong enable flag shows up in the first turbo or shadow access below 0x3000 after the control write. A fault in window decoding shows up at once as a bad ram_hit or slow_cycle, or as an address at or above 0x8000 that has been altered. The bench therefore places probe accesses right after each flag-changing event. It also walks the 0x2FFF/0x3000 and 0xBFFF/0xC000/0xDFFF/0xE000 boundaries.

// File: rtl/shremap_pkg.sv
`timescale 1ns/1ps
package shremap_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TURBO  = 2'd1,
    MODE_SHADOW = 2'd2,
    MODE_ALT    = 2'd3
  } remap_mode_e;
endpackage

// File: rtl/map_enable_reg.sv
`timescale 1ns/1ps
module map_enable_reg #(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFC7F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          ctrl_bit,
  output logic          mapped
);
  logic hit_ctrl;
  assign hit_ctrl = wr && (addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           mapped <= 1'b1;
    else if (hit_ctrl) mapped <= ~ctrl_bit;
  end

  // R2
  mapped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_ctrl |=> $stable(mapped));
endmodule

// File: rtl/fetch_region_tracker.sv
`timescale 1ns/1ps
module fetch_region_tracker #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] DRV_MASK  = 16'hE000,
  parameter logic [AW-1:0] DRV_MATCH = 16'hC000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          sync,
  input  logic          rd,
  output logic          in_driver
);
  logic fetch;
  assign fetch = sync && rd;

  always_ff @(posedge clk) begin
    if (rst)        in_driver <= 1'b0;
    else if (fetch) in_driver <= ((addr & DRV_MASK) == DRV_MATCH);
  end

  // R4
  drv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(in_driver));
endmodule

// File: rtl/addr_translate.sv
`timescale 1ns/1ps
module addr_translate
  import shremap_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] WIN_TOP   = 16'h8000,
  parameter logic [AW-1:0] LOW_LIMIT = 16'h3000,
  parameter logic [AW-1:0] SHADOW_OFS = 16'h8000
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    mode,
  input  logic          mapped,
  input  logic          in_driver,
  output logic [AW-1:0] ram_addr,
  output logic          ram_hit,
  output logic          slow
);
  remap_mode_e m;
  logic        below_low;
  logic        shift;

  assign m         = remap_mode_e'(mode);
  assign ram_hit   = (rd || wr) && (addr < WIN_TOP);
  assign below_low = addr < LOW_LIMIT;

  always_comb begin
    shift = 1'b0;
    slow  = 1'b0;
    case (m)
      MODE_TURBO:  shift = mapped && below_low;
      MODE_SHADOW: shift = mapped && (below_low || !in_driver);
      default:     slow  = 1'b1;
    endcase
    shift = shift && ram_hit;
    slow  = slow && ram_hit;
  end

  assign ram_addr = shift ? (addr + SHADOW_OFS) : addr;
endmodule

// File: rtl/shadow_remap.sv
`timescale 1ns/1ps
module shadow_remap
  import shremap_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter int            CTRL_BIT   = 7,
  parameter logic [AW-1:0] CTRL_ADDR  = 16'hFC7F,
  parameter logic [AW-1:0] WIN_TOP    = 16'h8000,
  parameter logic [AW-1:0] LOW_LIMIT  = 16'h3000,
  parameter logic [AW-1:0] SHADOW_OFS = 16'h8000,
  parameter logic [AW-1:0] DRV_MASK   = 16'hE000,
  parameter logic [AW-1:0] DRV_MATCH  = 16'hC000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_sync,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [1:0]    mode,
  output logic [AW-1:0] ram_addr,
  output logic          ram_hit,
  output logic          slow_cycle
);
  localparam int OFS_BIT = $clog2(SHADOW_OFS);

  logic mapped;
  logic in_driver;
  logic unused_wdata;

  assign unused_wdata = ^cpu_wdata;

  map_enable_reg #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_en (
    .clk(clk), .rst(rst), .addr(cpu_addr), .wr(cpu_wr),
    .ctrl_bit(cpu_wdata[CTRL_BIT]), .mapped(mapped));

  fetch_region_tracker #(.AW(AW), .DRV_MASK(DRV_MASK), .DRV_MATCH(DRV_MATCH)) u_trk (
    .clk(clk), .rst(rst), .addr(cpu_addr), .sync(cpu_sync), .rd(cpu_rd),
    .in_driver(in_driver));

  addr_translate #(.AW(AW), .WIN_TOP(WIN_TOP), .LOW_LIMIT(LOW_LIMIT),
                   .SHADOW_OFS(SHADOW_OFS)) u_xl (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .mode(mode), .mapped(mapped),
    .in_driver(in_driver), .ram_addr(ram_addr), .ram_hit(ram_hit),
    .slow(slow_cycle));

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_hit |-> ram_addr == cpu_addr);

  // R8
  fast_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 || mode == 2'd2) |-> !slow_cycle);

  // R7
  slow_only_ram_chk: assert property (@(posedge clk) disable iff (rst)
    slow_cycle |-> ram_hit);

  // R2
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> ram_addr == cpu_addr);

  // R10
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ram_addr[OFS_BIT-1:0] == cpu_addr[OFS_BIT-1:0]);
endmodule

// File: tb/sim_shadow_remap.sv
`timescale 1ns/1ps
module sim_shadow_remap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_sync = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  mode = 2'd2;
  logic [15:0] ram_addr;
  logic        ram_hit, slow_cycle;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_remap u0 (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_sync(cpu_sync),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .mode(mode),
    .ram_addr(ram_addr), .ram_hit(ram_hit), .slow_cycle(slow_cycle));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One bus cycle: drive after negedge, sample outputs, let the edge pass.
  task automatic acc(input logic [15:0] a, input logic s, input logic r, input logic w,
                     input logic [7:0] d, output logic [15:0] ra, output logic h,
                     output logic sl);
    @(negedge clk);
    cpu_addr = a; cpu_sync = s; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    #1;
    ra = ram_addr; h = ram_hit; sl = slow_cycle;
    @(posedge clk); #1;
    cpu_sync = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic rdchk(input string tag, input logic [15:0] a, input logic [15:0] exp_a,
                       input logic exp_slow);
    logic [15:0] ra; logic h, sl;
    acc(a, 0, 1, 0, 8'h00, ra, h, sl);
    chk({tag, " addr"}, ra, exp_a);
    chk({tag, " slow"}, {15'd0, sl}, {15'd0, exp_slow});
  endtask

  task automatic fetch(input logic [15:0] a);
    logic [15:0] ra; logic h, sl;
    acc(a, 1, 1, 0, 8'h00, ra, h, sl);
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    logic [15:0] ra; logic h, sl;
    acc(16'hFC7F, 0, 0, 1, d, ra, h, sl);
    chk("R9 io write passthru", ra, 16'hFC7F);
    chk("R9 io write fast", {14'd0, h, sl}, 16'd0);
  endtask

  task automatic t_reset();
    mode = 2'd2;
    rdchk("R1 reset shadow 0x3000", 16'h3000, 16'hB000, 0);
    rdchk("R1 reset shadow 0x0100", 16'h0100, 16'h8100, 0);
  endtask

  task automatic t_ctrl();
    mode = 2'd1;
    ctrl_write(8'h80);
    rdchk("R2 disabled turbo", 16'h1000, 16'h1000, 0);
    mode = 2'd2;
    rdchk("R2 disabled shadow", 16'h5000, 16'h5000, 0);
    mode = 2'd1;
    ctrl_write(8'h7F);
    rdchk("R2 enabled turbo", 16'h1000, 16'h9000, 0);
  endtask

  task automatic t_turbo();
    mode = 2'd1;
    rdchk("R5 turbo 0x2FFF", 16'h2FFF, 16'hAFFF, 0);
    rdchk("R5 turbo 0x3000", 16'h3000, 16'h3000, 0);
    rdchk("R5 turbo 0x7FFF", 16'h7FFF, 16'h7FFF, 0);
    rdchk("R8 turbo low", 16'h0000, 16'h8000, 0);
  endtask

  task automatic t_shadow();
    logic [15:0] ra; logic h, sl;
    mode = 2'd2;
    fetch(16'hC123);
    rdchk("R3 drv set 0x3000", 16'h3000, 16'h3000, 0);
    rdchk("R6 drv set 0x2FFF", 16'h2FFF, 16'hAFFF, 0);
    rdchk("R4 data read high", 16'h9000, 16'h9000, 0);
    acc(16'h4000, 0, 0, 1, 8'h55, ra, h, sl);
    chk("R4 write keeps drv", ra, 16'h4000);
    rdchk("R4 drv still set", 16'h5000, 16'h5000, 0);
    fetch(16'hE000);
    rdchk("R3 drv clear 0xE000", 16'h5000, 16'hD000, 0);
    fetch(16'hDFFF);
    rdchk("R3 drv set 0xDFFF", 16'h6000, 16'h6000, 0);
    acc(16'h4000, 1, 1, 0, 8'h00, ra, h, sl);
    chk("R10 fetch from RAM uses old drv", ra, 16'h4000);
    rdchk("R3 drv clear after RAM fetch", 16'h4000, 16'hC000, 0);
    fetch(16'hBFFF);
    rdchk("R3 drv clear 0xBFFF", 16'h7000, 16'hF000, 0);
    fetch(16'hC000);
    acc(16'h7000, 0, 0, 0, 8'h00, ra, h, sl);
    chk("R9 idle not ram", {14'd0, h, sl}, 16'd0);
    rdchk("R4 idle keeps drv", 16'h7000, 16'h7000, 0);
  endtask

  task automatic t_normal();
    logic [15:0] ra; logic h, sl;
    mode = 2'd0;
    rdchk("R7 normal 0x1000", 16'h1000, 16'h1000, 1);
    acc(16'h2000, 0, 0, 1, 8'h00, ra, h, sl);
    chk("R7 normal write", {ra[15:2], h, sl}, {14'h0800, 1'b1, 1'b1});
    mode = 2'd3;
    rdchk("R7 mode3 0x0500", 16'h0500, 16'h0500, 1);
    acc(16'h9000, 0, 1, 0, 8'h00, ra, h, sl);
    chk("R9 high read", {ra[15:2], h, sl}, {14'h2400, 1'b0, 1'b0});
  endtask

  task automatic t_high();
    logic [15:0] ra; logic h, sl;
    mode = 2'd2;
    acc(16'hFC00, 0, 1, 0, 8'h00, ra, h, sl);
    chk("R9 io page read", ra, 16'hFC00);
    chk("R9 io page fast", {14'd0, h, sl}, 16'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_ctrl();
    t_turbo();
    t_shadow();
    t_normal();
    t_high();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule